// File: doc/BRIEF.md
# Triggered Single-Pulse PWM Timer

This block is one up-counting timer channel that produces a PWM or compare reference waveform. The counter runs from zero up to a reload value, then wraps to zero and raises an update flag. A run begins either from a software start strobe or from an active edge on an external trigger input. Before edge detection, that input passes through polarity selection, a digital filter and an edge prescaler.

In one-shot mode the channel produces exactly one counting period. At the update event the counter clears itself and stops. A second run then needs a new start. A fast-compare option lets a trigger-started one-shot pulse drive the reference to its post-match level on the very next cycle, without waiting for the registered compare pipeline. Software can stop the counter at any time, and the count is kept.

Top module: `trig_pulse_timer`

## Requirements
- R1: While reset is asserted, count, running, oc_ref, upd_flag and trg_flag are all 0.
- R2: With cfg_trig_en set, an accepted trigger edge sets running on the second clock edge after ext_trig changes, with count still 0 in that cycle. While running is 0, count holds its value.
- R3: Trigger conditioning applies three settings before edge detection. cfg_trig_pol=1 inverts ext_trig. cfg_trig_filt=N>0 accepts a level only after N consecutive differing samples, so shorter glitches are dropped. cfg_trig_psc=P passes only every 2^P-th rising edge.
- R4: While running, count increments by one each cycle. In the cycle after count equals cfg_reload, count is 0 and upd_flag is 1 for one cycle.
- R5: With cfg_one_shot=1, the update event clears count to 0 and drops running. A software-started pulse keeps running high for cfg_reload+1 cycles.
- R6: sw_stop drops running on the next edge and holds count, even when it coincides with the reload cycle. In that case count stays at cfg_reload and no update flag is raised.
- R7: Mode encodings are 00 = PWM-A (oc_ref high while count < cfg_compare), 01 = PWM-B (inverse), 10 = toggle, 11 = forced low. The compare result reaches oc_ref two cycles after count.
- R8: With cfg_fast=1, cfg_one_shot=1 and a PWM mode, a trigger-started pulse forces oc_ref to its post-match level (0 for PWM-A, 1 for PWM-B) in the first running cycle. The level is held until the pulse ends.
- R9: cfg_fast has no effect when the pulse is started by sw_start or when the mode is not PWM-A or PWM-B.
- R10: In one-shot mode, a trigger edge that arrives while running is 1 is ignored, including one in the reload cycle itself. It neither restarts nor extends the pulse.
- R11: trg_flag is 1 for exactly one cycle after each edge that passes the prescaler, whether or not it starts the counter.
- R12: In toggle mode, oc_ref inverts once each time the running counter equals cfg_compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_reload | input | CW | Reload (period end) value |
| cfg_compare | input | CW | Channel compare value |
| cfg_mode | input | 2 | Reference mode: 00 PWM-A, 01 PWM-B, 10 toggle, 11 low |
| cfg_one_shot | input | 1 | One-shot (single period) enable |
| cfg_fast | input | 1 | Fast-compare enable |
| cfg_trig_en | input | 1 | Allow trigger edges to start the counter |
| cfg_trig_pol | input | 1 | Invert the trigger input |
| cfg_trig_psc | input | PW | Trigger edge prescaler exponent |
| cfg_trig_filt | input | FW | Trigger filter length in samples, 0 = none |
| sw_start | input | 1 | Software start strobe |
| sw_stop | input | 1 | Software stop strobe |
| ext_trig | input | 1 | External trigger input |
| count | output | CW | Counter value |
| running | output | 1 | Counter enabled |
| oc_ref | output | 1 | Compare reference output |
| upd_flag | output | 1 | One-cycle update event flag |
| trg_flag | output | 1 | One-cycle accepted trigger edge flag |

## Verification
Two events can fall in the same cycle: a trigger edge that passes conditioning, and the one-shot update event at the reload value. The bench provokes this by starting a one-shot pulse from software. It then raises ext_trig so that the edge detector fires exactly in the reload cycle. The result is correct when, one cycle later, both flags are set, count is 0, running is 0, and running stays low afterwards. A second collision is also covered: sw_stop landing in the reload cycle, where the stop must win and the count must stay at the reload value.

// File: rtl/tpt_pkg.sv
package tpt_pkg;

  typedef enum logic [1:0] {
    OCM_PWM_A  = 2'b00,
    OCM_PWM_B  = 2'b01,
    OCM_TOGGLE = 2'b10,
    OCM_LOW    = 2'b11
  } oc_mode_e;

  function automatic logic mode_is_pwm(oc_mode_e m);
    return (m == OCM_PWM_A) || (m == OCM_PWM_B);
  endfunction

endpackage

// File: rtl/tpt_trig_cond.sv
module tpt_trig_cond #(
  parameter int FW = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_trig,
  input  logic          cfg_pol,
  input  logic [PW-1:0] cfg_psc,
  input  logic [FW-1:0] cfg_filt,
  output logic          trig_evt
);
  localparam int PCW = (1 << PW) - 1;

  logic           samp_q, samp_d;
  logic           filt_q, filt_d;
  logic [FW-1:0]  fcnt_q, fcnt_d;
  logic           prev_q;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic [PCW-1:0] pmax;
  logic           level;
  logic           rise;

  always_comb begin
    samp_d = ext_trig ^ cfg_pol;
    filt_d = filt_q;
    fcnt_d = '0;
    if (cfg_filt == '0) begin
      filt_d = samp_q;
    end else if (samp_q != filt_q) begin
      if (fcnt_q >= (cfg_filt - FW'(1))) filt_d = samp_q;
      else                               fcnt_d = fcnt_q + FW'(1);
    end
    level    = (cfg_filt == '0) ? samp_q : filt_q;
    rise     = level & ~prev_q;
    pmax     = (PCW'(1) << cfg_psc) - PCW'(1);
    trig_evt = rise && (pcnt_q >= pmax);
    pcnt_d   = pcnt_q;
    if (rise) pcnt_d = (pcnt_q >= pmax) ? '0 : pcnt_q + PCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      filt_q <= 1'b0;
      fcnt_q <= '0;
      prev_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      samp_q <= samp_d;
      filt_q <= filt_d;
      fcnt_q <= fcnt_d;
      prev_q <= level;
      pcnt_q <= pcnt_d;
    end
  end

endmodule

// File: rtl/tpt_counter.sv
module tpt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_reload,
  input  logic          cfg_one_shot,
  input  logic          cfg_trig_en,
  input  logic          sw_start,
  input  logic          sw_stop,
  input  logic          trig_evt,
  output logic [CW-1:0] count,
  output logic          running,
  output logic          upd_evt,
  output logic          trig_start,
  output logic          upd_flag,
  output logic          trg_flag
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          trig_ok;

  always_comb begin
    upd_evt    = run_q && (cnt_q == cfg_reload) && !sw_stop;
    trig_ok    = trig_evt && cfg_trig_en && !(cfg_one_shot && run_q);
    trig_start = trig_ok && !run_q && !sw_start && !sw_stop;

    run_d = run_q;
    if (sw_stop)                      run_d = 1'b0;
    else if (upd_evt && cfg_one_shot) run_d = 1'b0;
    else if (sw_start || trig_ok)     run_d = 1'b1;

    cnt_d = cnt_q;
    if (run_q && !sw_stop) begin
      if (upd_evt) cnt_d = '0;
      else         cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      run_q    <= 1'b0;
      upd_flag <= 1'b0;
      trg_flag <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      run_q    <= run_d;
      upd_flag <= upd_evt;
      trg_flag <= trig_evt;
    end
  end

  assign count   = cnt_q;
  assign running = run_q;

endmodule

// File: rtl/tpt_compare.sv
module tpt_compare
  import tpt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          running,
  input  logic [CW-1:0] cfg_compare,
  input  oc_mode_e      mode,
  input  logic          fast_start,
  input  logic          pulse_end,
  output logic          oc_ref
);
  logic lt_q, lt_d;
  logic hit_q, hit_d;
  logic fast_q, fast_d;
  logic ref_q, ref_d;
  logic post_lvl;

  always_comb begin
    lt_d     = count < cfg_compare;
    hit_d    = running && (count == cfg_compare);
    post_lvl = (mode == OCM_PWM_B);

    fast_d = fast_q;
    if (pulse_end)       fast_d = 1'b0;
    else if (fast_start) fast_d = 1'b1;

    if (fast_start || (fast_q && !pulse_end)) begin
      ref_d = post_lvl;
    end else begin
      unique case (mode)
        OCM_PWM_A:  ref_d = lt_q;
        OCM_PWM_B:  ref_d = !lt_q;
        OCM_TOGGLE: ref_d = hit_q ? !ref_q : ref_q;
        default:    ref_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lt_q   <= 1'b0;
      hit_q  <= 1'b0;
      fast_q <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      lt_q   <= lt_d;
      hit_q  <= hit_d;
      fast_q <= fast_d;
      ref_q  <= ref_d;
    end
  end

  assign oc_ref = ref_q;

endmodule

// File: rtl/trig_pulse_timer.sv
module trig_pulse_timer
  import tpt_pkg::*;
#(
  parameter int CW = 16,
  parameter int FW = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_reload,
  input  logic [CW-1:0] cfg_compare,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_one_shot,
  input  logic          cfg_fast,
  input  logic          cfg_trig_en,
  input  logic          cfg_trig_pol,
  input  logic [PW-1:0] cfg_trig_psc,
  input  logic [FW-1:0] cfg_trig_filt,
  input  logic          sw_start,
  input  logic          sw_stop,
  input  logic          ext_trig,
  output logic [CW-1:0] count,
  output logic          running,
  output logic          oc_ref,
  output logic          upd_flag,
  output logic          trg_flag
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       trig_evt;
  logic       upd_evt;
  logic       trig_start;
  logic       fast_start;
  logic       pulse_end;
  oc_mode_e   mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign mode       = oc_mode_e'(cfg_mode);
  assign fast_start = trig_start && cfg_fast && cfg_one_shot && mode_is_pwm(mode);
  assign pulse_end  = (upd_evt && cfg_one_shot) || sw_stop;

  tpt_trig_cond #(.FW(FW), .PW(PW)) u_cond (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ext_trig (ext_trig),
    .cfg_pol  (cfg_trig_pol),
    .cfg_psc  (cfg_trig_psc),
    .cfg_filt (cfg_trig_filt),
    .trig_evt (trig_evt)
  );

  tpt_counter #(.CW(CW)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cfg_reload   (cfg_reload),
    .cfg_one_shot (cfg_one_shot),
    .cfg_trig_en  (cfg_trig_en),
    .sw_start     (sw_start),
    .sw_stop      (sw_stop),
    .trig_evt     (trig_evt),
    .count        (count),
    .running      (running),
    .upd_evt      (upd_evt),
    .trig_start   (trig_start),
    .upd_flag     (upd_flag),
    .trg_flag     (trg_flag)
  );

  tpt_compare #(.CW(CW)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .count       (count),
    .running     (running),
    .cfg_compare (cfg_compare),
    .mode        (mode),
    .fast_start  (fast_start),
    .pulse_end   (pulse_end),
    .oc_ref      (oc_ref)
  );

endmodule

// File: rtl/tpt_checker.sv
module tpt_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cfg_reload,
  input logic [1:0]    cfg_mode,
  input logic          cfg_one_shot,
  input logic          cfg_fast,
  input logic          cfg_trig_en,
  input logic          sw_start,
  input logic          sw_stop,
  input logic          trig_evt,
  input logic [CW-1:0] count,
  input logic          running,
  input logic          oc_ref,
  input logic          upd_flag,
  input logic          trg_flag
);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(count));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !sw_stop && count != cfg_reload) |=> count == $past(count) + CW'(1));

  assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !sw_stop && count == cfg_reload) |=> (count == '0) && upd_flag);

  assert_one_shot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !sw_stop && cfg_one_shot && count == cfg_reload) |=> !running);

  assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stop |=> !running && (count == $past(count)));

  assert_fast_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_evt && cfg_trig_en && cfg_fast && cfg_one_shot && !running &&
     !sw_start && !sw_stop && !cfg_mode[1]) |=> oc_ref == $past(cfg_mode[0]));

  assert_busy_trigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_evt && cfg_one_shot && running && !sw_stop && count == cfg_reload) |=> !running);

  assert_flag_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trg_flag |=> !trg_flag);

endmodule

bind trig_pulse_timer tpt_checker #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .cfg_reload   (cfg_reload),
  .cfg_mode     (cfg_mode),
  .cfg_one_shot (cfg_one_shot),
  .cfg_fast     (cfg_fast),
  .cfg_trig_en  (cfg_trig_en),
  .sw_start     (sw_start),
  .sw_stop      (sw_stop),
  .trig_evt     (trig_evt),
  .count        (count),
  .running      (running),
  .oc_ref       (oc_ref),
  .upd_flag     (upd_flag),
  .trg_flag     (trg_flag)
);

// File: tb/sim_trig_pulse_timer.sv
module sim_trig_pulse_timer;
  localparam int CW = 16;
  localparam int FW = 4;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cfg_reload, cfg_compare;
  logic [1:0]    cfg_mode;
  logic          cfg_one_shot, cfg_fast, cfg_trig_en, cfg_trig_pol;
  logic [PW-1:0] cfg_trig_psc;
  logic [FW-1:0] cfg_trig_filt;
  logic          sw_start, sw_stop, ext_trig;
  logic [CW-1:0] count;
  logic          running, oc_ref, upd_flag, trg_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  trig_pulse_timer #(.CW(CW), .FW(FW), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_reload(cfg_reload), .cfg_compare(cfg_compare),
    .cfg_mode(cfg_mode), .cfg_one_shot(cfg_one_shot), .cfg_fast(cfg_fast),
    .cfg_trig_en(cfg_trig_en), .cfg_trig_pol(cfg_trig_pol), .cfg_trig_psc(cfg_trig_psc),
    .cfg_trig_filt(cfg_trig_filt), .sw_start(sw_start), .sw_stop(sw_stop),
    .ext_trig(ext_trig), .count(count), .running(running), .oc_ref(oc_ref),
    .upd_flag(upd_flag), .trg_flag(trg_flag)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_run_len(int arr);
    return arr + 1;
  endfunction

  function automatic int exp_post_len(int arr, int ccr);
    return arr - ccr + 1;
  endfunction

  function automatic int exp_pwm(int mode, int cnt, int ccr);
    int lt;
    lt = (cnt < ccr) ? 1 : 0;
    return (mode == 0) ? lt : 1 - lt;
  endfunction

  // one-shot run from the held value back to zero
  task automatic drain();
    cfg_one_shot = 1'b1;
    sw_start = 1'b1;
    tick();
    sw_start = 1'b0;
    repeat (int'(cfg_reload) + 3) tick();
    chk("R5 drain count", int'(count), 0);
    chk("R5 drain running", int'(running), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int runs, posts, upds, trans, prev, r0;
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    cfg_reload = 16'd9; cfg_compare = 16'd4; cfg_mode = 2'b00;
    cfg_one_shot = 1'b0; cfg_fast = 1'b0; cfg_trig_en = 1'b0; cfg_trig_pol = 1'b0;
    cfg_trig_psc = '0; cfg_trig_filt = '0;
    sw_start = 1'b0; sw_stop = 1'b0; ext_trig = 1'b0;
    repeat (3) tick();
    // R1 reset values
    chk("R1 count", int'(count), 0);
    chk("R1 running", int'(running), 0);
    chk("R1 oc_ref", int'(oc_ref), 0);
    chk("R1 upd_flag", int'(upd_flag), 0);
    chk("R1 trg_flag", int'(trg_flag), 0);
    rst_n = 1'b1;
    repeat (5) tick();

    // R2 and R3 polarity: inverted trigger, falling pin edge starts
    cfg_trig_pol = 1'b1;
    tick();
    ext_trig = 1'b1;
    repeat (4) tick();
    cfg_trig_en = 1'b1;
    repeat (4) tick();
    chk("R2 held count", int'(count), 0);
    chk("R2 held running", int'(running), 0);
    ext_trig = 1'b0;
    tick();
    chk("R2 not yet running", int'(running), 0);
    tick();
    chk("R2 start running", int'(running), 1);
    chk("R2 start count", int'(count), 0);
    chk("R11 flag set", int'(trg_flag), 1);
    tick();
    chk("R4 first step", int'(count), 1);
    chk("R11 flag one cycle", int'(trg_flag), 0);
    repeat (2) tick();
    chk("R4 third step", int'(count), 3);
    // R6 stop holds value
    sw_stop = 1'b1;
    tick();
    sw_stop = 1'b0;
    chk("R6 stopped", int'(running), 0);
    chk("R6 held", int'(count), 3);
    repeat (3) tick();
    chk("R6 still held", int'(count), 3);
    cfg_trig_en = 1'b0;
    cfg_trig_pol = 1'b0;
    tick();
    drain();

    // R6 stop in the reload cycle wins
    cfg_one_shot = 1'b0;
    sw_start = 1'b1;
    tick();
    sw_start = 1'b0;
    repeat (9) tick();
    sw_stop = 1'b1;
    tick();
    sw_stop = 1'b0;
    chk("R6 stop at reload count", int'(count), 9);
    chk("R6 stop at reload running", int'(running), 0);
    chk("R6 stop at reload no update", int'(upd_flag), 0);
    drain();

    // R4 continuous wrap
    cfg_one_shot = 1'b0;
    cfg_reload = 16'd5;
    sw_start = 1'b1;
    tick();
    sw_start = 1'b0;
    for (int i = 0; i < 14; i++) begin
      chk("R4 count sequence", int'(count), i % 6);
      chk("R4 update flag", int'(upd_flag), (i > 0 && i % 6 == 0) ? 1 : 0);
      tick();
    end
    sw_stop = 1'b1;
    tick();
    sw_stop = 1'b0;
    drain();

    // R12 toggle mode
    cfg_one_shot = 1'b0;
    cfg_mode = 2'b10;
    cfg_compare = 16'd2;
    sw_start = 1'b1;
    tick();
    sw_start = 1'b0;
    repeat (8) tick();
    prev = int'(oc_ref);
    trans = 0;
    for (int i = 0; i < 36; i++) begin
      tick();
      if (int'(oc_ref) != prev) trans++;
      prev = int'(oc_ref);
    end
    chk("R12 toggles per period", trans, 6);
    sw_stop = 1'b1;
    tick();
    sw_stop = 1'b0;
    drain();

    // R7 PWM latency in both senses
    cfg_reload = 16'd9;
    cfg_compare = 16'd4;
    for (int m = 0; m < 2; m++) begin
      cfg_one_shot = 1'b1;
      cfg_mode = 2'(m);
      repeat (3) tick();
      sw_start = 1'b1;
      tick();
      sw_start = 1'b0;
      for (int i = 0; i < 15; i++) begin
        int c;
        c = (i - 2 >= 0 && i - 2 <= 9) ? i - 2 : 0;
        chk("R7 reference level", int'(oc_ref), exp_pwm(m, c, 4));
        tick();
      end
    end

    // R8 fast compare, R10 trigger during pulse ignored
    cfg_mode = 2'b00;
    cfg_reload = 16'd20;
    cfg_one_shot = 1'b1;
    cfg_fast = 1'b1;
    cfg_trig_en = 1'b1;
    repeat (3) tick();
    ext_trig = 1'b1;
    tick();
    tick();
    chk("R8 running", int'(running), 1);
    runs = 0;
    for (int i = 0; i < 30; i++) begin
      if (running) runs++;
      chk("R8 forced level", int'(oc_ref), (i >= 23) ? 1 : 0);
      if (i == 5) ext_trig = 1'b0;
      if (i == 8) ext_trig = 1'b1;
      tick();
    end
    chk("R10 pulse not extended", runs, exp_run_len(20));
    chk("R10 final count", int'(count), 0);
    ext_trig = 1'b0;
    repeat (3) tick();

    // R9 fast ignored on software start
    sw_start = 1'b1;
    tick();
    sw_start = 1'b0;
    tick();
    chk("R9 software start no force", int'(oc_ref), 1);
    repeat (2) tick();
    chk("R9 software start still high", int'(oc_ref), 1);
    repeat (25) tick();

    // R9 fast ignored in toggle mode
    cfg_mode = 2'b10;
    repeat (3) tick();
    r0 = int'(oc_ref);
    ext_trig = 1'b1;
    tick();
    tick();
    chk("R9 toggle start running", int'(running), 1);
    chk("R9 toggle no force", int'(oc_ref), r0);
    repeat (2) tick();
    chk("R9 toggle no force later", int'(oc_ref), r0);
    repeat (25) tick();
    ext_trig = 1'b0;
    cfg_mode = 2'b00;
    cfg_fast = 1'b0;
    cfg_reload = 16'd10;
    repeat (3) tick();

    // R3 prescaler divide by two
    cfg_trig_psc = 2'd1;
    ext_trig = 1'b1;
    repeat (3) tick();
    ext_trig = 1'b0;
    repeat (3) tick();
    chk("R3 prescaler first edge dropped", int'(running), 0);
    ext_trig = 1'b1;
    tick();
    tick();
    chk("R3 prescaler second edge starts", int'(running), 1);
    ext_trig = 1'b0;
    repeat (15) tick();
    cfg_trig_psc = '0;

    // R3 filter rejects a short glitch
    cfg_trig_filt = 4'd3;
    ext_trig = 1'b1;
    tick();
    tick();
    ext_trig = 1'b0;
    repeat (8) tick();
    chk("R3 filter glitch dropped", int'(running), 0);
    ext_trig = 1'b1;
    repeat (8) tick();
    chk("R3 filter stable level starts", int'(running), 1);
    ext_trig = 1'b0;
    repeat (15) tick();
    cfg_trig_filt = '0;
    repeat (2) tick();

    // R10 trigger edge in the reload cycle
    sw_start = 1'b1;
    tick();
    sw_start = 1'b0;
    repeat (9) tick();
    ext_trig = 1'b1;
    tick();
    tick();
    chk("R10 collision running", int'(running), 0);
    chk("R10 collision count", int'(count), 0);
    chk("R10 collision update", int'(upd_flag), 1);
    chk("R11 collision trigger flag", int'(trg_flag), 1);
    repeat (3) tick();
    chk("R10 no restart", int'(running), 0);
    ext_trig = 1'b0;
    cfg_trig_en = 1'b0;
    repeat (3) tick();

    // R5 and R7 randomized one-shot pulses
    for (int it = 0; it < 40; it++) begin
      int arr, ccr, m;
      arr = 1 + int'($urandom % 40);
      ccr = 1 + int'($urandom % arr);
      m   = int'($urandom % 2);
      cfg_reload  = CW'(arr);
      cfg_compare = CW'(ccr);
      cfg_mode    = 2'(m);
      repeat (3) tick();
      sw_start = 1'b1;
      tick();
      sw_start = 1'b0;
      runs = 0; posts = 0; upds = 0;
      for (int i = 0; i < arr + 8; i++) begin
        if (running) runs++;
        if (int'(oc_ref) == m) posts++;
        if (upd_flag) upds++;
        tick();
      end
      chk("R5 run length", runs, exp_run_len(arr));
      chk("R7 post-match length", posts, exp_post_len(arr, ccr));
      chk("R5 single update", upds, 1);
      chk("R5 cleared", int'(count), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule